// File: doc/BRIEF.md
# Burst-Aligned Word Packer with Zero Padding

The block sits at the tail of a compressed image byte stream and feeds a burst-oriented bus master. Bytes arrive one per handshake on a valid/ready interface, and the final byte of each frame carries a last flag. That final byte is the closing byte of the end-of-image marker (0xFF then 0xD9). The block packs the bytes, unchanged, into 64-bit words.

After the last byte it appends 0x00 bytes until the frame's total emitted length is a whole number of 128-byte chunks. A downstream burst engine can therefore move fixed 16-word bursts and needs no partial-transfer logic. The output side is a 64-bit valid/ready word stream with a flag that marks the closing word of every chunk.

A 7-bit position counter tracks where the stream sits inside the current chunk. While padding words are being produced, the byte input is stalled. When the frame ends on a chunk boundary, the counter is already at zero and no padding is produced. The counter then starts the next frame at zero.

Top module: `chunk_align_packer`

## Requirements
- R1: After reset, `outValid` and `outBurstLast` are 0 and `inReady` is 1 while the output side is idle.
- R2: Byte n of a frame (counting from 0) appears unchanged in output word n/8 of that frame, at bits [8*(n mod 8)+7 : 8*(n mod 8)] (little-endian lane order).
- R3: When the eighth byte of a word (lane 7) is accepted, that word is presented on `outValid` in the next cycle.
- R4: After the byte carrying `inLast`, every remaining byte lane up to the next 128-byte boundary is emitted as 0x00. A frame of L bytes is emitted as exactly ceil(L/128)*16 words.
- R5: A frame whose length is a multiple of 128 gets no padding. The word after its last word is the first word of the next frame.
- R6: `outBurstLast` is 1 exactly on the 16th, 32nd, 48th, ... accepted word of the stream, and 0 on all other words.
- R7: `inReady` is 0 whenever `outValid` is 1 and `outReady` is 0. No byte of the next frame is accepted while more than one word of the previous frame (the one held in the output register) remains unaccepted.
- R8: While `outValid` is 1 and `outReady` is 0, the next cycle keeps `outValid` at 1 and holds `outData` and `outBurstLast` unchanged.
- R9: Each frame starts at lane 0 of a fresh word and a fresh chunk. Its byte 0 lands in bits [7:0] of the first word after the previous frame's padding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inData | input | 8 | Compressed byte |
| inValid | input | 1 | Byte offered |
| inLast | input | 1 | Byte is the final marker byte of the frame |
| inReady | output | 1 | Byte accepted this cycle when inValid is also 1 |
| outData | output | 64 | Packed word, byte 0 in bits [7:0] |
| outValid | output | 1 | Word offered |
| outBurstLast | output | 1 | Word is the 16th of its 128-byte chunk |
| outReady | input | 1 | Downstream takes the word this cycle |

## Verification
A byte accepted into lane 7 is due on `outValid` one cycle after its acceptance edge. A held word must be unchanged one cycle after a refused handshake. Padding words follow one per cycle in which the output register is free. The bench therefore drives inputs just after each rising edge and samples every port at the falling edge, where it arms one-cycle-ahead expectations for R3 and R8. It sweeps frame lengths across every residue near one, two and three chunk boundaries, with pseudo-periodic back-pressure and input gaps. Each accepted word is compared against bytes and padding computed from the frame length alone.

// File: rtl/chunk_pad_pkg.sv
package chunk_pad_pkg;

  typedef struct packed {
    logic writeByte;
    logic emitWord;
    logic burstLast;
  } padCtrl_t;

  typedef enum logic {
    ST_DATA = 1'b0,
    ST_PAD  = 1'b1
  } padState_e;

endpackage

// File: rtl/chunk_pad_ctrl.sv
module chunk_pad_ctrl
  import chunk_pad_pkg::*;
#(
  parameter int WORD_BYTES  = 8,
  parameter int CHUNK_BYTES = 128,
  localparam int POS_W  = $clog2(CHUNK_BYTES),
  localparam int LANE_W = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  input  logic              outValid,
  input  logic              outReady,
  output logic [LANE_W-1:0] lane,
  output padCtrl_t          ctrl
);

  padState_e        state, stateNext;
  logic [POS_W-1:0] pos, posNext;
  logic             outFree;
  logic             take;
  logic             laneFull;
  logic             chunkEnd;
  logic             posMax;
  logic             padEmit;

  assign outFree  = !outValid || outReady;
  assign inReady  = (state == ST_DATA) && outFree;
  assign take     = inValid && inReady;
  assign lane     = pos[LANE_W-1:0];
  assign laneFull = &pos[LANE_W-1:0];
  assign chunkEnd = &pos[POS_W-1:LANE_W];
  assign posMax   = &pos;
  assign padEmit  = (state == ST_PAD) && outFree;

  always_comb begin
    ctrl.writeByte = take;
    ctrl.emitWord  = (take && laneFull) || padEmit;
    ctrl.burstLast = chunkEnd;
  end

  always_comb begin
    posNext   = pos;
    stateNext = state;
    if (take) begin
      posNext = pos + POS_W'(1);
      if (inLast && !posMax) stateNext = ST_PAD;
    end else if (padEmit) begin
      posNext = {pos[POS_W-1:LANE_W] + (POS_W-LANE_W)'(1), {LANE_W{1'b0}}};
      if (chunkEnd) stateNext = ST_DATA;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_DATA;
      pos   <= '0;
    end else begin
      state <= stateNext;
      pos   <= posNext;
    end
  end

  // R7: a refused word blocks byte intake
  p_stall_on_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  // R7: a frame end off a chunk boundary stalls intake next cycle
  p_stall_after_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inLast && !posMax) |=> !inReady);

  // R9: leaving the padding phase puts the counter back at the chunk start
  p_restart_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(state == ST_PAD) |-> (pos == '0));

  // R5: a frame ending on the boundary never enters padding
  p_no_pad_on_boundary_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inLast && posMax) |=> (state == ST_DATA));

endmodule

// File: rtl/chunk_pad_datapath.sv
module chunk_pad_datapath
  import chunk_pad_pkg::*;
#(
  parameter int WORD_BYTES  = 8,
  parameter int CHUNK_BYTES = 128,
  localparam int LANE_W     = $clog2(WORD_BYTES),
  localparam int WORD_W     = WORD_BYTES * 8,
  localparam int CHUNK_WORDS = CHUNK_BYTES / WORD_BYTES,
  localparam int WCNT_W     = $clog2(CHUNK_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        inData,
  input  logic [LANE_W-1:0] lane,
  input  padCtrl_t          ctrl,
  input  logic              outReady,
  output logic [WORD_W-1:0] outData,
  output logic              outValid,
  output logic              outBurstLast
);

  logic [WORD_W-1:0] wordBuf;
  logic [WORD_W-1:0] nextBuf;

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
    assign nextBuf[8*k +: 8] = (ctrl.writeByte && (lane == LANE_W'(k)))
                               ? inData : wordBuf[8*k +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordBuf      <= '0;
      outData      <= '0;
      outValid     <= 1'b0;
      outBurstLast <= 1'b0;
    end else begin
      wordBuf <= ctrl.emitWord ? '0 : nextBuf;
      if (ctrl.emitWord) begin
        outData      <= nextBuf;
        outValid     <= 1'b1;
        outBurstLast <= ctrl.burstLast;
      end else if (outReady) begin
        outValid     <= 1'b0;
        outBurstLast <= 1'b0;
      end
    end
  end

  // checker-only count of accepted words within the chunk
  logic [WCNT_W-1:0] hsCount;
  always_ff @(posedge clk) begin
    if (!rstN) hsCount <= '0;
    else if (outValid && outReady) hsCount <= hsCount + WCNT_W'(1);
  end

  // R8: a refused word is held
  p_hold_word_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outBurstLast)));

  // R6: burst flag only on the last word of each chunk
  p_burst_flag_pos_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outBurstLast) |-> (hsCount == WCNT_W'(CHUNK_WORDS-1)));

  // R6: the last word of each chunk carries the flag
  p_burst_flag_seen_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (hsCount == WCNT_W'(CHUNK_WORDS-1))) |-> outBurstLast);

  // R3: a new word is only loaded when the output register is free
  p_no_overwrite_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.emitWord |-> (!outValid || outReady));

endmodule

// File: rtl/chunk_align_packer.sv
module chunk_align_packer
  import chunk_pad_pkg::*;
#(
  parameter int WORD_BYTES  = 8,
  parameter int CHUNK_BYTES = 128,
  localparam int LANE_W = $clog2(WORD_BYTES),
  localparam int WORD_W = WORD_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic [WORD_W-1:0] outData,
  output logic              outValid,
  output logic              outBurstLast,
  input  logic              outReady
);

  padCtrl_t          ctrl;
  logic [LANE_W-1:0] lane;

  chunk_pad_ctrl #(
    .WORD_BYTES (WORD_BYTES),
    .CHUNK_BYTES(CHUNK_BYTES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inLast  (inLast),
    .inReady (inReady),
    .outValid(outValid),
    .outReady(outReady),
    .lane    (lane),
    .ctrl    (ctrl)
  );

  chunk_pad_datapath #(
    .WORD_BYTES (WORD_BYTES),
    .CHUNK_BYTES(CHUNK_BYTES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .inData      (inData),
    .lane        (lane),
    .ctrl        (ctrl),
    .outReady    (outReady),
    .outData     (outData),
    .outValid    (outValid),
    .outBurstLast(outBurstLast)
  );

endmodule

// File: tb/chunk_align_packer_test.sv
`timescale 1ns/1ps
module chunk_align_packer_test;

  localparam int NFRAMES = 79;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  inData = '0;
  logic        inValid = 1'b0;
  logic        inLast = 1'b0;
  logic        inReady;
  logic [63:0] outData;
  logic        outValid;
  logic        outBurstLast;
  logic        outReady = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit timedOut = 0;

  always #2.5 clk = ~clk;

  chunk_align_packer uut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .outData(outData), .outValid(outValid),
    .outBurstLast(outBurstLast), .outReady(outReady)
  );

  function automatic int lenOf(input int f);
    if (f < 48) return f + 1;
    if (f < 65) return 120 + (f - 48);
    if (f < 76) return 250 + (f - 65);
    return 383 + (f - 76);
  endfunction

  function automatic logic [7:0] byteOf(input int f, input int i, input int len);
    if (i == len - 1) return 8'hD9;
    if (i == len - 2) return 8'hFF;
    return 8'((i * 37 + f * 11 + 5) & 255);
  endfunction

  function automatic int wordsOf(input int len);
    return ((len + 127) / 128) * 16;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // back-pressure generator
  int cyc = 0;
  initial begin
    wait (rstN);
    forever begin
      @(posedge clk); #1;
      cyc++;
      outReady = !(((cyc % 5) == 3) || ((cyc % 97) < 6));
    end
  end

  // monitor state
  int mf = 0, mw = 0;
  int inFrame = 0, inIdx = 0;
  bit r3Due = 0, holdDue = 0;
  logic [63:0] heldData;
  logic heldLast;

  always @(negedge clk) begin
    if (rstN && !done && !timedOut) begin
      if (r3Due) chk(outValid == 1'b1, "R3 word due after lane 7", 64'(outValid), 64'd1);
      r3Due = 0;
      if (holdDue) begin
        chk(outValid == 1'b1, "R8 valid held", 64'(outValid), 64'd1);
        chk(outData == heldData, "R8 data held", outData, heldData);
        chk(outBurstLast == heldLast, "R8 flag held", 64'(outBurstLast), 64'(heldLast));
      end
      holdDue = outValid && !outReady;
      heldData = outData;
      heldLast = outBurstLast;
      if (outValid && !outReady)
        chk(inReady == 1'b0, "R7 ready low on held word", 64'(inReady), 64'd0);

      if (inValid && inReady) begin
        if (inIdx == 0 && inFrame > 0) begin
          int pend;
          pend = 0;
          if (mf < inFrame - 1) pend = 1000;
          else if (mf == inFrame - 1) pend = wordsOf(lenOf(mf)) - mw;
          chk(pend <= 1, "R7 intake during padding", 64'(pend), 64'd1);
        end
        if ((inIdx % 8) == 7) r3Due = 1;
        if (inIdx == lenOf(inFrame) - 1) begin
          inFrame++;
          inIdx = 0;
        end else inIdx++;
      end

      if (outValid && outReady) begin
        int len;
        bit anyPad;
        logic [63:0] exp;
        len = lenOf(mf);
        anyPad = 0;
        exp = '0;
        for (int k = 0; k < 8; k++) begin
          int b;
          b = mw * 8 + k;
          if (b < len) exp[8*k +: 8] = byteOf(mf, b, len);
          else anyPad = 1;
        end
        if (anyPad) chk(outData == exp, "R4 padded word", outData, exp);
        else chk(outData == exp, "R2 data word", outData, exp);
        chk(outBurstLast == ((mw % 16) == 15), "R6 burst flag",
            64'(outBurstLast), 64'((mw % 16) == 15));
        if (mw == 0 && mf > 0) begin
          if ((lenOf(mf - 1) % 128) == 0)
            chk(outData[7:0] == byteOf(mf, 0, len), "R5 no pad on boundary",
                64'(outData[7:0]), 64'(byteOf(mf, 0, len)));
          else
            chk(outData[7:0] == byteOf(mf, 0, len), "R9 frame restarts at lane 0",
                64'(outData[7:0]), 64'(byteOf(mf, 0, len)));
        end
        mw++;
        if (mw == wordsOf(len)) begin
          mw = 0;
          mf++;
          if (mf == NFRAMES) done = 1;
        end
      end
    end
  end

  task automatic driveFrames();
    for (int f = 0; f < NFRAMES; f++) begin
      int len;
      len = lenOf(f);
      for (int i = 0; i < len; i++) begin
        bit got;
        if (((i * 3 + f) % 7) == 5) begin
          inValid = 1'b0;
          @(posedge clk); #1;
        end
        inValid = 1'b1;
        inData  = byteOf(f, i, len);
        inLast  = (i == len - 1);
        do begin
          @(negedge clk);
          got = inReady;
          @(posedge clk); #1;
        end while (!got);
      end
      inValid = 1'b0;
      inLast  = 1'b0;
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R1 valid after reset", 64'(outValid), 64'd0);
    chk(outBurstLast == 1'b0, "R1 flag after reset", 64'(outBurstLast), 64'd0);
    chk(inReady == 1'b1, "R1 ready after reset", 64'(inReady), 64'd1);
    @(posedge clk); #1;
    fork
      driveFrames();
    join_none
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        timedOut = 1;
      end
    join_any
    if (timedOut && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog frames=%0d expected=%0d", mf, NFRAMES);
    end
    repeat (4) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule